// File: doc/BRIEF.md
# Transaction Status FIFO Window

This block records one status byte for every completed bus transaction and holds up to four of them in arrival order. Software never addresses the queue directly. It sees only the oldest entry, through a 32-bit read-only status word. A transaction-complete flag is tied to the queue. The flag stays high while any entry is waiting. A write-one-to-clear of that flag removes the oldest entry and brings the next one forward.

The transfer engine raises a one-cycle completion strobe. With it come the endpoint number, a transmit/receive bit and a bit that selects the odd or even descriptor bank. The occupancy controller is a three-state machine:

- `OCC_EMPTY`: no entries are queued.
- `OCC_PART`: one to three entries are queued.
- `OCC_FULL`: four entries are queued.

It has four named transitions:

- `T_FILL` (`OCC_EMPTY`→`OCC_PART`): first push.
- `T_TOP` (`OCC_PART`→`OCC_FULL`): a push with no pop while three entries are held.
- `T_DRAIN` (`OCC_PART`→`OCC_EMPTY`): a pop with no push while one entry is held.
- `T_FREE` (`OCC_FULL`→`OCC_PART`): a pop with no push.

A strobe that finds the queue full is lost and sets a sticky overflow indication.

Top module: `txn_status_fifo`

## Requirements
- R1: Up to four entries are held and presented strictly in arrival order, one at a time, oldest first.
- R2: While the flag is high, status bits 7:4 give the oldest entry's endpoint (0..15), bit 3 is 1 for transmit and 0 for receive, and bit 2 is 1 for the odd bank and 0 for the even bank.
- R3: Status bits 31:8 and 1:0 always read 0.
- R4: The flag is high exactly when at least one entry is queued; it rises on the clock edge that stores the first strobe.
- R5: Asserting the clear input while the flag is high removes the oldest entry on that clock edge; the next entry is presented from the following cycle, and the flag stays high if entries remain.
- R6: Asserting the clear input while the queue is empty changes nothing: the flag stays low and the status stays 0.
- R7: A strobe arriving while four entries are held, with no clear in the same cycle, is discarded and sets the overflow output, which stays high until reset.
- R8: A strobe and a clear in the same cycle are both honoured, even when the queue is full, so the occupancy is unchanged and the new entry goes to the tail.
- R9: While the queue is empty the status word reads all zeros.
- R10: After reset the queue is empty, the flag and the overflow output are low, and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_valid | input | 1 | One-cycle transaction-complete strobe |
| done_endp | input | 4 | Endpoint number of the completed transaction |
| done_tx | input | 1 | 1 = transmit, 0 = receive |
| done_odd | input | 1 | 1 = odd descriptor bank, 0 = even |
| flag_clr | input | 1 | Write-one-to-clear of the completion flag (pops the oldest entry) |
| status_rd | output | 32 | Formatted view of the oldest entry |
| xfer_flag | output | 1 | Transaction-complete flag, high while entries are queued |
| ovf_sticky | output | 1 | Sticky lost-strobe indication |

## Verification
The bench fills the queue to four entries and then strobes again. A design that wrapped its write pointer would overwrite the oldest entry, and the next status would show the newest one. It also applies a strobe and a clear together, both on a full queue and on a one-entry queue. Getting that wrong either drops the new entry or empties the queue and lowers the flag too early. A clear on an empty queue must leave the flag low, so a pointer that underflows shows stale data. Long patterned runs of mixed strobes and clears check the reserved bits, and that the status word is zeroed whenever the flag is low.

// File: rtl/txst_pkg.sv
package txst_pkg;
    localparam int EP_W = 4;

    typedef struct packed {
        logic [EP_W-1:0] endp;
        logic            tx;
        logic            odd;
    } txst_entry_t;

    localparam int ENTRY_W = $bits(txst_entry_t);

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;
endpackage

// File: rtl/txst_ctrl.sv
module txst_ctrl #(
    parameter int DEPTH = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       push_req,
    input  logic                                       pop_req,
    output logic                                       wr_en,
    output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] wr_ptr,
    output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rd_ptr,
    output logic                                       not_empty,
    output logic                                       ovf
);
    import txst_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    occ_state_t    state_q, state_d;
    logic [CW-1:0] count_q, count_d;
    logic [PW-1:0] wp_q, rp_q;
    logic          ovf_q;
    logic          pop_ok, push_ok, drop;

    function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PW'(1);
    endfunction

    // Acceptance decisions
    always_comb begin
        pop_ok  = pop_req && (state_q != OCC_EMPTY);
        push_ok = push_req && ((state_q != OCC_FULL) || pop_ok);
        drop    = push_req && !push_ok;
    end

    // Next-state logic: T_FILL, T_TOP, T_DRAIN, T_FREE
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (push_ok && !pop_ok) count_d = count_q + CW'(1);
        if (pop_ok && !push_ok) count_d = count_q - CW'(1);
        unique case (state_q)
            OCC_EMPTY: begin
                if (push_ok) state_d = OCC_PART;                              // T_FILL
            end
            OCC_PART: begin
                if (push_ok && !pop_ok && count_q == CNT_TOP) state_d = OCC_FULL;   // T_TOP
                else if (pop_ok && !push_ok && count_q == CNT_ONE) state_d = OCC_EMPTY; // T_DRAIN
            end
            OCC_FULL: begin
                if (pop_ok && !push_ok) state_d = OCC_PART;                   // T_FREE
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count_q <= '0;
            wp_q    <= '0;
            rp_q    <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (push_ok) wp_q <= ptr_step(wp_q);
            if (pop_ok)  rp_q <= ptr_step(rp_q);
            if (drop)    ovf_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        wr_en     = push_ok;
        wr_ptr    = wp_q;
        rd_ptr    = rp_q;
        not_empty = (state_q != OCC_EMPTY);
        ovf       = ovf_q;
    end
endmodule

// File: rtl/txst_store.sv
module txst_store #(
    parameter int DEPTH = 4,
    parameter int PW    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PW-1:0]         wr_ptr,
    input  txst_pkg::txst_entry_t wr_data,
    input  logic [PW-1:0]         rd_ptr,
    output txst_pkg::txst_entry_t rd_data
);
    import txst_pkg::*;

    txst_entry_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                 slot_q[g] <= '0;
            else if (wr_en && (wr_ptr == PW'(g)))       slot_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_ptr == PW'(i)) rd_data = slot_q[i];
        end
    end
endmodule

// File: rtl/txst_fmt.sv
module txst_fmt #(
    parameter int REG_W = 32
) (
    input  logic                  valid,
    input  txst_pkg::txst_entry_t head,
    output logic [REG_W-1:0]      word
);
    import txst_pkg::*;

    localparam int ODD_BIT = 2;
    localparam int TX_BIT  = 3;
    localparam int EP_LSB  = 4;

    always_comb begin
        word = '0;
        if (valid) begin
            word[ODD_BIT]                 = head.odd;
            word[TX_BIT]                  = head.tx;
            word[EP_LSB +: EP_W]          = head.endp;
        end
    end
endmodule

// File: rtl/txn_status_fifo.sv
module txn_status_fifo #(
    parameter int DEPTH = 4,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_valid,
    input  logic [3:0]       done_endp,
    input  logic             done_tx,
    input  logic             done_odd,
    input  logic             flag_clr,
    output logic [REG_W-1:0] status_rd,
    output logic             xfer_flag,
    output logic             ovf_sticky
);
    import txst_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          wr_en, not_empty;
    logic [PW-1:0] wr_ptr, rd_ptr;
    txst_entry_t   in_entry, head;

    always_comb begin
        in_entry.endp = done_endp;
        in_entry.tx   = done_tx;
        in_entry.odd  = done_odd;
    end

    txst_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .push_req(done_valid), .pop_req(flag_clr),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .not_empty(not_empty), .ovf(ovf_sticky)
    );

    txst_store #(.DEPTH(DEPTH), .PW(PW)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(in_entry),
        .rd_ptr(rd_ptr), .rd_data(head)
    );

    txst_fmt #(.REG_W(REG_W)) fmt_i (
        .valid(not_empty), .head(head), .word(status_rd)
    );

    assign xfer_flag = not_empty;
endmodule

// File: rtl/txst_chk.sv
module txst_chk #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_valid,
    input logic             flag_clr,
    input logic [REG_W-1:0] status_rd,
    input logic             xfer_flag,
    input logic             ovf_sticky
);
    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd[REG_W-1:8] == '0) && (status_rd[1:0] == 2'b00));

    assert_empty_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_flag |-> (status_rd == '0));

    assert_push_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> xfer_flag);

    assert_clear_empty_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_flag && flag_clr && !done_valid) |=> !xfer_flag);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky);

    assert_ovf_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_sticky) |-> $past(xfer_flag && done_valid && !flag_clr));
endmodule

bind txn_status_fifo txst_chk #(.REG_W(REG_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .done_valid(done_valid), .flag_clr(flag_clr),
    .status_rd(status_rd), .xfer_flag(xfer_flag), .ovf_sticky(ovf_sticky)
);

// File: tb/txn_status_fifo_tb_top.sv
module txn_status_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QDEPTH     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_valid = 1'b0;
    logic [3:0]  done_endp = '0;
    logic        done_tx = 1'b0;
    logic        done_odd = 1'b0;
    logic        flag_clr = 1'b0;
    logic [31:0] status_rd;
    logic        xfer_flag;
    logic        ovf_sticky;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] mq[$];
    bit         m_ovf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_status_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .done_valid(done_valid), .done_endp(done_endp),
        .done_tx(done_tx), .done_odd(done_odd), .flag_clr(flag_clr),
        .status_rd(status_rd), .xfer_flag(xfer_flag), .ovf_sticky(ovf_sticky)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        logic [31:0] exp_stat;
        exp_stat = (mq.size() > 0) ? {24'h0, mq[0]} : 32'h0;
        check(req, "status", status_rd, exp_stat);
        check(req, "flag", {31'h0, xfer_flag}, {31'h0, mq.size() > 0});
        check(req, "overflow", {31'h0, ovf_sticky}, {31'h0, m_ovf});
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(input string req, input bit v, input logic [3:0] ep,
                        input bit tx, input bit odd, input bit clr);
        bit pop, push;
        done_valid = v; done_endp = ep; done_tx = tx; done_odd = odd; flag_clr = clr;
        @(posedge clk);
        pop  = clr && (mq.size() > 0);
        push = v && ((mq.size() < QDEPTH) || pop);
        if (v && !push) m_ovf = 1;
        if (pop)  void'(mq.pop_front());
        if (push) mq.push_back({ep, tx, odd, 2'b00});
        @(negedge clk);
        done_valid = 0; flag_clr = 0;
        compare_all(req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R10");

        // R4 R2: first entry, transmit on odd bank
        step("R4", 1, 4'd9, 1, 1, 0);
        // R1: fill to four with varied fields
        step("R1", 1, 4'd0, 0, 0, 0);
        step("R1", 1, 4'd15, 1, 0, 0);
        step("R2", 1, 4'd6, 0, 1, 0);
        // R7: fifth strobe dropped, overflow sticky
        step("R7", 1, 4'd3, 1, 1, 0);
        step("R7", 0, 4'd0, 0, 0, 0);
        // R8: push and pop together while full
        step("R8", 1, 4'd12, 1, 0, 1);
        // R5: drain in order
        step("R5", 0, 4'd0, 0, 0, 1);
        step("R5", 0, 4'd0, 0, 0, 1);
        step("R1", 0, 4'd0, 0, 0, 1);
        step("R5", 0, 4'd0, 0, 0, 1);
        // R9: empty reads zero
        step("R9", 0, 4'd0, 0, 0, 0);
        // R6: clear while empty
        step("R6", 0, 4'd0, 0, 0, 1);
        step("R6", 0, 4'd0, 0, 0, 1);
        // R8: push and pop together with one entry
        step("R8", 1, 4'd1, 0, 1, 0);
        step("R8", 1, 4'd2, 1, 1, 1);
        step("R5", 0, 4'd0, 0, 0, 1);
        step("R9", 0, 4'd0, 0, 0, 0);

        // R3: long patterned mix of strobes and clears
        lfsr = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step("R3", lfsr[0] | lfsr[7], lfsr[6:3], lfsr[2], lfsr[1], lfsr[5] & lfsr[2]);
        end

        // R10: reset again clears everything
        rst_n = 1'b0;
        @(posedge clk);
        mq.delete(); m_ovf = 0;
        @(negedge clk);
        rst_n = 1'b1;
        compare_all("R10");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule